// File: doc/BRIEF.md
# Link Active-State Exit Arbiter

This block holds the next-state decision for the normal operating state of a serial link training state machine. In every cycle where the training machine reports that it is in the active state, the arbiter looks at the per-lane ordered-set indications, the higher-layer directives, the recorded partner rate capability and the link control bits. It then registers a one-hot choice of where the link goes next: stay active, Recovery, L0s for the transmitter only, L0s for the receiver only, L1 or L2.

The block also owns three pieces of state. The first is the link-up status. The second is a record that the partner has advertised a rate above 2.5 GT/s since the link last left Detect. The third is the directed speed-change flag. It also emits two one-cycle strobes. One clears the idle-to-lock counter kept elsewhere. The other clears the changed-speed-recovery bit when a speed change is taken for equalization.

All outputs are registered, so each one reflects the inputs sampled at the previous rising clock edge.

Top module: `link_exit_arb`

## Requirements
- R1: After reset `linkUp` is 0. It becomes 1 one cycle after `inL0` is seen high and stays 1 until `leftDetect` is seen while `inL0` is low. `inL0` wins when both are high.
- R2: `clrIdleCnt` pulses one cycle after a start-symbol indication on any configured lane (`startRx & laneCfg` nonzero) while `inL0` is high. Otherwise it is 0.
- R3: The rate record is cleared by `leftDetect` and set by `partnerRateAdv`, with clear winning. `speedChgFlag` is never 1 unless the record is set, and `leftDetect` clears the flag.
- R4: While in the active state with the record set, `speedChgFlag` is set by `hlSpeedReq`. On a downstream port (`dsPort`=1) it is also set by `retrainBit` with `targetSpeed` different from `curSpeed`. On an upstream port the retrain bit alone does not set it.
- R5: With `speedChgFlag`=1 the arbiter picks Recovery if any of three conditions holds: `localHiRate`, the record and `dlActive` are all set; or `local8g` and `partner8g` are both set; or `altProtoBad` is set. Taking this exit clears the flag. `clrEqRecov` pulses with it when `local8g` and `partner8g` are both set.
- R6: A TS1 or TS2 on a configured lane selects Recovery. An EIEOS on a configured lane selects Recovery only when `enc128`=1. Indications on unconfigured lanes are ignored.
- R7: With no low-power directive (`lpDir`=0), an EIOS on any lane selects receive-only L0s when `rxL0sImpl`=1. When `rxL0sImpl`=0 it selects Recovery, unless `widthShrinkExp`=1, in which case the link stays active.
- R8: `widthChgReq`, `recovReq` or `retrainBit` each select Recovery.
- R9: `txL0sReq` selects transmit-only L0s only when `txL0sImpl`=1.
- R10: With `lpDir`=1 (L1) or `lpDir`=2 (L2), an EIOS on any lane together with `eiosTxDone` selects L1 or L2 respectively. An EIOS with a low-power directive pending selects neither L0s nor Recovery.
- R11: `nextSt` is one-hot with bit 0 stay, bit 1 Recovery, bit 2 transmit L0s, bit 3 receive L0s, bit 4 L1 and bit 5 L2. The priority is L1/L2 first, then Recovery, then receive L0s, then transmit L0s, then stay. `nextSt` is all zero one cycle after `inL0` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inL0 | input | 1 | Training machine is in the active state |
| dsPort | input | 1 | 1 for a downstream port |
| leftDetect | input | 1 | Pulse: link has just left Detect |
| partnerRateAdv | input | 1 | Pulse: partner advertised a rate above 2.5 GT/s |
| localHiRate | input | 1 | Local port supports a rate above 2.5 GT/s |
| local8g | input | 1 | Local port supports 8.0 GT/s or more |
| partner8g | input | 1 | Partner supports 8.0 GT/s or more |
| dlActive | input | 1 | Data link layer is active |
| altProtoBad | input | 1 | Alternate protocol active and current rate not allowed by it |
| hlSpeedReq | input | 1 | Higher layer requests a speed change |
| retrainBit | input | 1 | Retrain request from the link control register |
| targetSpeed | input | SPD_W | Target link speed field |
| curSpeed | input | SPD_W | Current link speed |
| widthChgReq | input | 1 | Higher layer directs a width change |
| recovReq | input | 1 | Higher layer directs Recovery |
| laneCfg | input | LANES | Configured-lane mask |
| ts1Rx | input | LANES | TS1 received, per lane |
| ts2Rx | input | LANES | TS2 received, per lane |
| eieosRx | input | LANES | EIEOS received, per lane |
| eiosRx | input | LANES | EIOS received, per lane |
| startRx | input | LANES | STP or SDP start symbol received, per lane |
| enc128 | input | 1 | 128b/130b or 1b/1b encoding in use |
| widthShrinkExp | input | 1 | EIOS expected as part of a width reduction |
| rxL0sImpl | input | 1 | Receiver implements L0s |
| txL0sImpl | input | 1 | Transmitter implements L0s |
| txL0sReq | input | 1 | Higher layer directs transmitter L0s |
| lpDir | input | 2 | Low-power directive: 0 none, 1 L1, 2 L2 |
| eiosTxDone | input | 1 | EIOS sequence sent on all lanes |
| linkUp | output | 1 | Link-up status |
| nextSt | output | 6 | One-hot next-state choice |
| speedChgFlag | output | 1 | Directed speed-change flag |
| clrIdleCnt | output | 1 | Strobe: clear idle-to-lock counter |
| clrEqRecov | output | 1 | Strobe: clear changed-speed-recovery bit |

## Verification
The bench targets four classes of collision and gating error.

- **Low-power priority.** It fires an EIOS in the same cycle as a low-power completion and as a TS1. A design with a wrong priority would report Recovery or L0s instead of L1 or L2.
- **Lane and encoding gating.** It places TS and EIEOS indications only on unconfigured lanes, and it sends EIEOS with the older encoding. A design that skipped the lane mask or the encoding gate would leave the active state spuriously.
- **Rate record.** It requests a speed change before any partner advertisement, and it retrains an upstream port with differing speeds. A design that ignored the record or the port role would raise the speed flag.
- **Flag lifetime.** It checks that the flag falls when the speed exit is taken. A design that kept it set would loop through Recovery.

// File: rtl/link_exit_arb_pkg.sv
package link_exit_arb_pkg;

  localparam int NS_W     = 6;
  localparam int NS_STAY  = 0;
  localparam int NS_RECOV = 1;
  localparam int NS_TXL0S = 2;
  localparam int NS_RXL0S = 3;
  localparam int NS_L1    = 4;
  localparam int NS_L2    = 5;

  typedef enum logic [1:0] {
    LP_NONE = 2'd0,
    LP_L1   = 2'd1,
    LP_L2   = 2'd2
  } lpDir_e;

  // lane-level summaries handed from datapath to control
  typedef struct packed {
    logic anyTs;
    logic anyEieos;
    logic anyEios;
    logic anyStart;
    logic spdNeq;
  } laneEvt_t;

  // strobes handed from control to datapath
  typedef struct packed {
    logic [NS_W-1:0] nxt;
    logic            clrIdle;
    logic            clrEq;
    logic            setSpd;
    logic            clrSpd;
    logic            setHi;
    logic            clrHi;
    logic            setUp;
    logic            clrUp;
  } ctlStrobes_t;

endpackage

// File: rtl/link_exit_arb_ctl.sv
module link_exit_arb_ctl
  import link_exit_arb_pkg::*;
(
  input  logic                inL0,
  input  logic                dsPort,
  input  logic                leftDetect,
  input  logic                partnerRateAdv,
  input  logic                localHiRate,
  input  logic                local8g,
  input  logic                partner8g,
  input  logic                dlActive,
  input  logic                altProtoBad,
  input  logic                hlSpeedReq,
  input  logic                retrainBit,
  input  logic                widthChgReq,
  input  logic                recovReq,
  input  logic                enc128,
  input  logic                widthShrinkExp,
  input  logic                rxL0sImpl,
  input  logic                txL0sImpl,
  input  logic                txL0sReq,
  input  logic [1:0]          lpDir,
  input  logic                eiosTxDone,
  input  laneEvt_t            evt,
  input  logic                hiRateSeen,
  input  logic                speedFlag,
  output ctlStrobes_t         stb
);

  lpDir_e lpMode;
  logic   both8, spdExit, goL1, goL2, goRecov, goRxL0s, goTxL0s, lpPending;

  always_comb begin
    lpMode    = lpDir_e'(lpDir);
    lpPending = (lpMode != LP_NONE);
    both8     = local8g && partner8g;
    spdExit   = inL0 && speedFlag &&
                ((localHiRate && hiRateSeen && dlActive) || both8 || altProtoBad);
    goL1      = inL0 && (lpMode == LP_L1) && evt.anyEios && eiosTxDone;
    goL2      = inL0 && (lpMode == LP_L2) && evt.anyEios && eiosTxDone;
    goRecov   = inL0 && (spdExit || widthChgReq || recovReq || retrainBit ||
                         evt.anyTs || (enc128 && evt.anyEieos) ||
                         (evt.anyEios && !rxL0sImpl && !lpPending && !widthShrinkExp));
    goRxL0s   = inL0 && evt.anyEios && rxL0sImpl && !lpPending;
    goTxL0s   = inL0 && txL0sReq && txL0sImpl;
  end

  always_comb begin
    stb = '0;
    if (goL2)         stb.nxt[NS_L2]    = 1'b1;
    else if (goL1)    stb.nxt[NS_L1]    = 1'b1;
    else if (goRecov) stb.nxt[NS_RECOV] = 1'b1;
    else if (goRxL0s) stb.nxt[NS_RXL0S] = 1'b1;
    else if (goTxL0s) stb.nxt[NS_TXL0S] = 1'b1;
    else if (inL0)    stb.nxt[NS_STAY]  = 1'b1;

    stb.clrIdle = inL0 && evt.anyStart;
    stb.clrEq   = spdExit && both8 && stb.nxt[NS_RECOV];
    stb.clrSpd  = leftDetect || (spdExit && stb.nxt[NS_RECOV]);
    stb.setSpd  = inL0 && hiRateSeen &&
                  (hlSpeedReq || (dsPort && retrainBit && evt.spdNeq));
    stb.clrHi   = leftDetect;
    stb.setHi   = partnerRateAdv;
    stb.setUp   = inL0;
    stb.clrUp   = leftDetect;
  end

endmodule

// File: rtl/link_exit_arb_dp.sv
module link_exit_arb_dp
  import link_exit_arb_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SPD_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inL0,
  input  logic [LANES-1:0]    laneCfg,
  input  logic [LANES-1:0]    ts1Rx,
  input  logic [LANES-1:0]    ts2Rx,
  input  logic [LANES-1:0]    eieosRx,
  input  logic [LANES-1:0]    eiosRx,
  input  logic [LANES-1:0]    startRx,
  input  logic [SPD_W-1:0]    targetSpeed,
  input  logic [SPD_W-1:0]    curSpeed,
  input  ctlStrobes_t         stb,
  output laneEvt_t            evt,
  output logic                hiRateSeen,
  output logic                speedFlag,
  output logic                linkUp,
  output logic [NS_W-1:0]     nextSt,
  output logic                clrIdleCnt,
  output logic                clrEqRecov
);

  logic [LANES-1:0] tsLane, eieLane, startLane;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign tsLane[g]    = laneCfg[g] & (ts1Rx[g] | ts2Rx[g]);
    assign eieLane[g]   = laneCfg[g] & eieosRx[g];
    assign startLane[g] = laneCfg[g] & startRx[g];
  end

  always_comb begin
    evt.anyTs    = |tsLane;
    evt.anyEieos = |eieLane;
    evt.anyEios  = |eiosRx;
    evt.anyStart = |startLane;
    evt.spdNeq   = (targetSpeed != curSpeed);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiRateSeen <= 1'b0;
      speedFlag  <= 1'b0;
      linkUp     <= 1'b0;
      nextSt     <= '0;
      clrIdleCnt <= 1'b0;
      clrEqRecov <= 1'b0;
    end else begin
      if (stb.clrHi)       hiRateSeen <= 1'b0;
      else if (stb.setHi)  hiRateSeen <= 1'b1;

      if (stb.clrSpd)      speedFlag <= 1'b0;
      else if (stb.setSpd) speedFlag <= 1'b1;

      if (stb.setUp)       linkUp <= 1'b1;
      else if (stb.clrUp)  linkUp <= 1'b0;

      nextSt     <= stb.nxt;
      clrIdleCnt <= stb.clrIdle;
      clrEqRecov <= stb.clrEq;
    end
  end

  // R3
  spd_needs_rate_chk: assert property (@(posedge clk) disable iff (!rstN)
    speedFlag |-> hiRateSeen);

  // R11
  next_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(nextSt));

  // R11
  idle_when_away_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inL0 |=> (nextSt == '0));

  // R1
  linkup_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    inL0 |=> linkUp);

endmodule

// File: rtl/link_exit_arb.sv
module link_exit_arb
  import link_exit_arb_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SPD_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inL0,
  input  logic              dsPort,
  input  logic              leftDetect,
  input  logic              partnerRateAdv,
  input  logic              localHiRate,
  input  logic              local8g,
  input  logic              partner8g,
  input  logic              dlActive,
  input  logic              altProtoBad,
  input  logic              hlSpeedReq,
  input  logic              retrainBit,
  input  logic [SPD_W-1:0]  targetSpeed,
  input  logic [SPD_W-1:0]  curSpeed,
  input  logic              widthChgReq,
  input  logic              recovReq,
  input  logic [LANES-1:0]  laneCfg,
  input  logic [LANES-1:0]  ts1Rx,
  input  logic [LANES-1:0]  ts2Rx,
  input  logic [LANES-1:0]  eieosRx,
  input  logic [LANES-1:0]  eiosRx,
  input  logic [LANES-1:0]  startRx,
  input  logic              enc128,
  input  logic              widthShrinkExp,
  input  logic              rxL0sImpl,
  input  logic              txL0sImpl,
  input  logic              txL0sReq,
  input  logic [1:0]        lpDir,
  input  logic              eiosTxDone,
  output logic              linkUp,
  output logic [5:0]        nextSt,
  output logic              speedChgFlag,
  output logic              clrIdleCnt,
  output logic              clrEqRecov
);

  laneEvt_t    evt;
  ctlStrobes_t stb;
  logic        hiRateSeen;

  link_exit_arb_ctl u_ctl (
    .inL0(inL0), .dsPort(dsPort), .leftDetect(leftDetect),
    .partnerRateAdv(partnerRateAdv), .localHiRate(localHiRate),
    .local8g(local8g), .partner8g(partner8g), .dlActive(dlActive),
    .altProtoBad(altProtoBad), .hlSpeedReq(hlSpeedReq),
    .retrainBit(retrainBit), .widthChgReq(widthChgReq), .recovReq(recovReq),
    .enc128(enc128), .widthShrinkExp(widthShrinkExp),
    .rxL0sImpl(rxL0sImpl), .txL0sImpl(txL0sImpl), .txL0sReq(txL0sReq),
    .lpDir(lpDir), .eiosTxDone(eiosTxDone), .evt(evt),
    .hiRateSeen(hiRateSeen), .speedFlag(speedChgFlag), .stb(stb)
  );

  link_exit_arb_dp #(.LANES(LANES), .SPD_W(SPD_W)) u_dp (
    .clk(clk), .rstN(rstN), .inL0(inL0), .laneCfg(laneCfg),
    .ts1Rx(ts1Rx), .ts2Rx(ts2Rx), .eieosRx(eieosRx), .eiosRx(eiosRx),
    .startRx(startRx), .targetSpeed(targetSpeed), .curSpeed(curSpeed),
    .stb(stb), .evt(evt), .hiRateSeen(hiRateSeen), .speedFlag(speedChgFlag),
    .linkUp(linkUp), .nextSt(nextSt), .clrIdleCnt(clrIdleCnt),
    .clrEqRecov(clrEqRecov)
  );

  // R10
  l1_complete_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inL0 && lpDir == 2'd1 && (|eiosRx) && eiosTxDone) |=> nextSt[NS_L1]);

  // R10
  l2_complete_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inL0 && lpDir == 2'd2 && (|eiosRx) && eiosTxDone) |=> nextSt[NS_L2]);

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inL0 && (|(startRx & laneCfg))) |=> clrIdleCnt);

  // R6
  unconfigured_ts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inL0 && lpDir == 2'd0 && eiosRx == '0 && !txL0sReq && !widthChgReq &&
     !recovReq && !retrainBit && !speedChgFlag &&
     ((ts1Rx | ts2Rx | eieosRx) & laneCfg) == '0) |=> nextSt[NS_STAY]);

endmodule

// File: tb/sim_link_exit_arb.sv
module sim_link_exit_arb;

  localparam int LANES = 4;
  localparam int SPD_W = 3;

  logic clk = 1'b0;
  logic rstN;
  logic inL0, dsPort, leftDetect, partnerRateAdv, localHiRate, local8g, partner8g;
  logic dlActive, altProtoBad, hlSpeedReq, retrainBit, widthChgReq, recovReq;
  logic [SPD_W-1:0] targetSpeed, curSpeed;
  logic [LANES-1:0] laneCfg, ts1Rx, ts2Rx, eieosRx, eiosRx, startRx;
  logic enc128, widthShrinkExp, rxL0sImpl, txL0sImpl, txL0sReq, eiosTxDone;
  logic [1:0] lpDir;
  logic linkUp, speedChgFlag, clrIdleCnt, clrEqRecov;
  logic [5:0] nextSt;

  int checks = 0;
  int failures = 0;
  bit mHi = 0, mSpd = 0, mUp = 0;
  logic [5:0] eNs;
  bit eIdle, eEq;

  always #5 clk = ~clk;

  link_exit_arb #(.LANES(LANES), .SPD_W(SPD_W)) u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearIn();
    inL0 = 1; dsPort = 0; leftDetect = 0; partnerRateAdv = 0; localHiRate = 0;
    local8g = 0; partner8g = 0; dlActive = 0; altProtoBad = 0; hlSpeedReq = 0;
    retrainBit = 0; widthChgReq = 0; recovReq = 0; targetSpeed = 0; curSpeed = 0;
    laneCfg = 4'b0011; ts1Rx = 0; ts2Rx = 0; eieosRx = 0; eiosRx = 0; startRx = 0;
    enc128 = 0; widthShrinkExp = 0; rxL0sImpl = 0; txL0sImpl = 0; txL0sReq = 0;
    lpDir = 0; eiosTxDone = 0;
  endtask

  // expected values from requirements R1..R11
  task automatic model();
    bit anyTs, anyEie, anyEios, anyStart, both8, spdExit, lpP, rec;
    bit nHi, nSpd, nUp;
    anyTs    = |((ts1Rx | ts2Rx) & laneCfg);
    anyEie   = |(eieosRx & laneCfg);
    anyEios  = |eiosRx;
    anyStart = |(startRx & laneCfg);
    both8    = local8g && partner8g;
    lpP      = lpDir != 0;
    spdExit  = inL0 && mSpd && ((localHiRate && mHi && dlActive) || both8 || altProtoBad);
    rec      = inL0 && (spdExit || widthChgReq || recovReq || retrainBit || anyTs ||
               (enc128 && anyEie) || (anyEios && !rxL0sImpl && !lpP && !widthShrinkExp));
    eNs = 6'd0;
    if (inL0 && lpDir == 2 && anyEios && eiosTxDone) eNs = 6'b100000;
    else if (inL0 && lpDir == 1 && anyEios && eiosTxDone) eNs = 6'b010000;
    else if (rec) eNs = 6'b000010;
    else if (inL0 && anyEios && rxL0sImpl && !lpP) eNs = 6'b001000;
    else if (inL0 && txL0sReq && txL0sImpl) eNs = 6'b000100;
    else if (inL0) eNs = 6'b000001;
    eIdle = inL0 && anyStart;
    eEq   = spdExit && both8 && eNs[1];
    nHi = leftDetect ? 1'b0 : (partnerRateAdv ? 1'b1 : mHi);
    if (leftDetect || (spdExit && eNs[1])) nSpd = 0;
    else if (inL0 && mHi && (hlSpeedReq || (dsPort && retrainBit && targetSpeed != curSpeed))) nSpd = 1;
    else nSpd = mSpd;
    nUp = inL0 ? 1'b1 : (leftDetect ? 1'b0 : mUp);
    mHi = nHi; mSpd = nSpd; mUp = nUp;
  endtask

  task automatic step();
    model();
    @(posedge clk);
    @(negedge clk);
    chk("R11 nextSt", 32'(nextSt), 32'(eNs));
    chk("R1 linkUp", 32'(linkUp), 32'(mUp));
    chk("R4 speedChgFlag", 32'(speedChgFlag), 32'(mSpd));
    chk("R2 clrIdleCnt", 32'(clrIdleCnt), 32'(eIdle));
    chk("R5 clrEqRecov", 32'(clrEqRecov), 32'(eEq));
  endtask

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    clearIn(); inL0 = 0; rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset linkUp", 32'(linkUp), 0);
    chk("R11 reset nextSt", 32'(nextSt), 0);
    chk("R3 reset speedChgFlag", 32'(speedChgFlag), 0);
    rstN = 1;

    // R1 link-up set and held
    clearIn(); step(); chk("R1 up", 32'(linkUp), 1);
    inL0 = 0; step(); chk("R1 held", 32'(linkUp), 1);
    chk("R11 away zero", 32'(nextSt), 0);
    leftDetect = 1; step(); chk("R1 cleared", 32'(linkUp), 0);

    // R6 lane mask and encoding gating
    clearIn(); ts1Rx = 4'b1100; step(); chk("R6 unconfigured ts", 32'(nextSt), 1);
    clearIn(); ts2Rx = 4'b0010; step(); chk("R6 ts2", 32'(nextSt), 2);
    clearIn(); eieosRx = 4'b0001; step(); chk("R6 eieos old enc", 32'(nextSt), 1);
    enc128 = 1; step(); chk("R6 eieos 128", 32'(nextSt), 2);

    // R7 EIOS handling
    clearIn(); eiosRx = 4'b1000; rxL0sImpl = 1; step(); chk("R7 rx L0s", 32'(nextSt), 8);
    rxL0sImpl = 0; step(); chk("R7 no L0s recov", 32'(nextSt), 2);
    widthShrinkExp = 1; step(); chk("R7 width shrink", 32'(nextSt), 1);

    // R8
    clearIn(); widthChgReq = 1; step(); chk("R8 width", 32'(nextSt), 2);
    clearIn(); retrainBit = 1; step(); chk("R8 retrain", 32'(nextSt), 2);

    // R9
    clearIn(); txL0sReq = 1; step(); chk("R9 no impl", 32'(nextSt), 1);
    txL0sImpl = 1; step(); chk("R9 tx L0s", 32'(nextSt), 4);

    // R10 and priority R11
    clearIn(); lpDir = 1; eiosRx = 4'b0001; rxL0sImpl = 1; step();
    chk("R10 pending no exit", 32'(nextSt), 1);
    eiosTxDone = 1; ts1Rx = 4'b0001; step(); chk("R11 L1 over recov", 32'(nextSt), 16);
    lpDir = 2; step(); chk("R10 L2", 32'(nextSt), 32);

    // R2
    clearIn(); startRx = 4'b0100; step(); chk("R2 unconfigured", 32'(clrIdleCnt), 0);
    startRx = 4'b0001; step(); chk("R2 clear", 32'(clrIdleCnt), 1);

    // R3 / R4 / R5 speed flow
    clearIn(); leftDetect = 1; step();
    clearIn(); hlSpeedReq = 1; step(); chk("R3 no record", 32'(speedChgFlag), 0);
    clearIn(); partnerRateAdv = 1; step();
    clearIn(); retrainBit = 1; targetSpeed = 3; curSpeed = 1; step();
    chk("R4 upstream retrain", 32'(speedChgFlag), 0);
    dsPort = 1; step(); chk("R4 downstream retrain", 32'(speedChgFlag), 1);
    clearIn(); step(); chk("R5 held no cond", 32'(nextSt), 1);
    local8g = 1; partner8g = 1; step();
    chk("R5 eq exit", 32'(nextSt), 2); chk("R5 eq strobe", 32'(clrEqRecov), 1);
    chk("R5 flag cleared", 32'(speedChgFlag), 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      inL0 = ($urandom % 8) != 0; dsPort = $urandom; leftDetect = ($urandom % 40) == 0;
      partnerRateAdv = ($urandom % 10) == 0; localHiRate = $urandom; local8g = $urandom;
      partner8g = $urandom; dlActive = $urandom; altProtoBad = ($urandom % 6) == 0;
      hlSpeedReq = ($urandom % 6) == 0; retrainBit = ($urandom % 10) == 0;
      targetSpeed = $urandom; curSpeed = $urandom;
      widthChgReq = ($urandom % 12) == 0; recovReq = ($urandom % 12) == 0;
      laneCfg = $urandom;
      ts1Rx = (($urandom % 6) == 0) ? 4'($urandom) : '0;
      ts2Rx = (($urandom % 8) == 0) ? 4'($urandom) : '0;
      eieosRx = (($urandom % 6) == 0) ? 4'($urandom) : '0;
      eiosRx = (($urandom % 4) == 0) ? 4'($urandom) : '0;
      startRx = (($urandom % 3) == 0) ? 4'($urandom) : '0;
      enc128 = $urandom; widthShrinkExp = ($urandom % 4) == 0;
      rxL0sImpl = $urandom; txL0sImpl = $urandom; txL0sReq = ($urandom % 4) == 0;
      lpDir = 2'($urandom % 3); eiosTxDone = $urandom;
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule